// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block pairs an 8-bit up-counting timer with a watchdog counter, and the two share a single 8-bit prescaler. A configuration bit chooses the prescaler's owner. When the timer owns it, the prescaler divides the timer's count source. When the watchdog owns it, the prescaler divides the watchdog tick. The client without the prescaler counts every one of its own events.

The timer counts one of two sources: the core clock, where every cycle is one event, or qualified edges of an asynchronous pin. Two flops synchronize the pin and a third flop finds its edges. A configuration bit picks the rising or the falling edge. When the timer wraps from FFh to 00h it sets a sticky overflow flag, which software clears. The watchdog counts a free-running tick and gives a one-cycle timeout pulse each time it wraps. A clear strobe restarts it.

Software reaches the block through a small register port. Writes are synchronous. Read data is combinational from the address.

Top module: `tmrwd_top`

## Requirements
- R1: After a synchronous active-low reset, the count register, the configuration register and the overflow flag read 0, and `wdt_timeout` is low. Reset configuration: core-clock source, rising edge, prescaler on the timer, rate 0.
- R2: Internal source with the prescaler on the timer: the timer advances once every 2^(rate+1) core-clock cycles, so rate 0 gives 1:2 and rate 7 gives 1:256.
- R3: With the prescaler on the watchdog (config bit 3 = 1), the timer advances on every source event: every cycle for the internal source, every qualified edge for the pin.
- R4: External source (config bit 5 = 1): `ext_clk_in` passes through two synchronizing flops and one edge flop. Config bit 4 = 0 selects rising edges and 1 selects falling edges. The timer takes one count per qualified edge, three clock edges after the pin changes.
- R5: A timer increment from FFh to 00h sets the overflow flag. A write to address 2 loads the flag from data bit 0. An overflow in the same cycle wins over that write.
- R6: A write to address 0 loads the timer, and the timer does not increment in that cycle. If the timer owns the prescaler, the write also clears the prescaler count.
- R7: The watchdog counter (WDT_W bits) advances on every tick when the timer owns the prescaler, and once every 2^rate ticks when the watchdog owns it. It pulses `wdt_timeout` high for one cycle in the cycle after it wraps from its maximum value.
- R8: `wdt_clear` zeroes the watchdog counter and has priority over a tick. If the watchdog owns the prescaler, it also clears the prescaler count. `wdt_timeout` is low in the cycle after a clear.
- R9: A configuration write that changes the ownership bit clears the prescaler count.
- R10: Register map:
  - Address 0: timer count.
  - Address 1: configuration. Bits 2:0 are the rate, bit 3 is ownership (1 = watchdog), bit 4 is the edge select, bit 5 is the source select. Bits 7:6 read 0.
  - Address 2: overflow flag in bit 0.
  - Address 3: reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one cycle is one instruction-clock event |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog tick, synchronous to `clk` |
| wdt_clear | input | 1 | Watchdog clear strobe |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
A wrong prescaler count does not show right away. It appears as a timer increment or a watchdog timeout that comes early or late by up to one full ratio. That can be as late as 256 cycles, or 128 watchdog ticks, after the faulty event. A missed prescaler clear, for example after a timer write, an ownership change or a watchdog clear, shows up at the next divided step. A wrong synchronizer depth or edge polarity moves every pin count by a cycle, or counts the opposite edge, within three cycles of the pin change. The reference model is compared with the read data, the flag and the timeout on every cycle, so each of these faults is caught at the first step where the outputs disagree.

// File: rtl/tmrwd_pkg.sv
// Package: shared types and register addresses for the timer/watchdog block.
// Assumes an 8-bit register data path and a 2-bit register address.
package tmrwd_pkg;

    localparam int DATA_W = 8;
    localparam int RATE_W = 3;
    localparam int CFG_W  = 6;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_CFG   = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;

    // Configuration word; member order fixes the bit positions (MSB first).
    typedef struct packed {
        logic              src_ext;     // bit 5: 1 = count pin edges
        logic              edge_fall;   // bit 4: 1 = falling edge
        logic              psc_to_wdt;  // bit 3: 1 = prescaler owned by watchdog
        logic [RATE_W-1:0] rate;        // bits 2:0: prescale rate code
    } tmrwd_cfg_t;

endpackage

// File: rtl/tmrwd_pin_sync.sv
// Module: synchronizes an asynchronous pin and emits a one-cycle pulse on
// the selected edge. Assumes the pin may change at any time relative to clk.
// SYNC_STAGES flops resynchronize; one more flop holds the previous level.
module tmrwd_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_fall,
    output logic edge_pulse
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Stage 0 captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin;
    end

    // Each further stage shifts the level one flop deeper.
    generate
        for (genvar g = 1; g < CHAIN; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    logic synced, prev;
    assign synced = chain_q[SYNC_STAGES-1];
    assign prev   = chain_q[SYNC_STAGES];

    // Edge qualification for the chosen polarity.
    always_comb begin
        if (edge_fall) edge_pulse = prev & ~synced;
        else           edge_pulse = synced & ~prev;
    end
endmodule

// File: rtl/tmrwd_prescaler.sv
// Module: shared binary prescaler. It counts step events and raises tap for
// the step that completes a ratio period. The timer ratio is 2^(rate+1) and
// the watchdog ratio is 2^rate. Assumes clr has priority over step.
module tmrwd_prescaler #(
    parameter int PSC_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              for_wdt,
    input  logic [RATE_W-1:0] rate,
    output logic              tap
);
    logic [PSC_W-1:0] cnt_q;
    logic [PSC_W-1:0] tmr_mask, wdt_mask, sel_mask;

    // Low-order masks selected by the rate code for each owner.
    always_comb begin
        for (int i = 0; i < PSC_W; i++) begin
            tmr_mask[i] = (i <= int'(rate));
            wdt_mask[i] = (i <  int'(rate));
        end
        sel_mask = for_wdt ? wdt_mask : tmr_mask;
        tap      = step && ((cnt_q & sel_mask) == sel_mask);
    end

    // Prescaler count: clear, advance on step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tmrwd_wdog.sv
// Module: watchdog counter with a registered one-cycle timeout pulse on wrap.
// Assumes clear has priority over an increment in the same cycle.
module tmrwd_wdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic timeout
);
    localparam logic [WDT_W-1:0] WDT_MAX = '1;

    logic [WDT_W-1:0] cnt_q;

    // Watchdog count and wrap detection.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            timeout <= 1'b0;
        end else if (inc) begin
            cnt_q   <= cnt_q + 1'b1;
            timeout <= (cnt_q == WDT_MAX);
        end else begin
            timeout <= 1'b0;
        end
    end
endmodule

// File: rtl/tmrwd_top.sv
// Module: 8-bit timer and watchdog sharing one prescaler, with a register
// port. Assumes wdt_tick and the register inputs are synchronous to clk, and
// that ext_clk_in is asynchronous.
module tmrwd_top
    import tmrwd_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int WDT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_clk_in,
    input  logic              wdt_tick,
    input  logic              wdt_clear,
    output logic              ovf_flag,
    output logic              wdt_timeout
);
    localparam logic [DATA_W-1:0] TMR_MAX = '1;

    tmrwd_cfg_t        cfg_q, cfg_new;
    logic [DATA_W-1:0] tmr_q;
    logic              flag_q;
    logic              wr_cnt, wr_cfg, wr_flag;
    logic              pin_edge, src_evt, psc_step, psc_clr, psc_tap;
    logic              tmr_inc, wdt_inc;

    // Register write decode.
    always_comb begin
        wr_cnt  = reg_wr_en && (reg_addr == ADDR_COUNT);
        wr_cfg  = reg_wr_en && (reg_addr == ADDR_CFG);
        wr_flag = reg_wr_en && (reg_addr == ADDR_FLAG);
        cfg_new = tmrwd_cfg_t'(reg_wdata[CFG_W-1:0]);
    end

    tmrwd_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ext_clk_in),
        .edge_fall  (cfg_q.edge_fall),
        .edge_pulse (pin_edge)
    );

    // Routing of events between the prescaler and its two possible owners.
    always_comb begin
        src_evt  = cfg_q.src_ext ? pin_edge : 1'b1;
        psc_step = cfg_q.psc_to_wdt ? wdt_tick : src_evt;
        psc_clr  = (wr_cnt && !cfg_q.psc_to_wdt)
                || (wdt_clear && cfg_q.psc_to_wdt)
                || (wr_cfg && (cfg_new.psc_to_wdt != cfg_q.psc_to_wdt));
        tmr_inc  = !wr_cnt && (cfg_q.psc_to_wdt ? src_evt : psc_tap);
        wdt_inc  = cfg_q.psc_to_wdt ? psc_tap : wdt_tick;
    end

    tmrwd_prescaler #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (psc_clr),
        .step    (psc_step),
        .for_wdt (cfg_q.psc_to_wdt),
        .rate    (cfg_q.rate),
        .tap     (psc_tap)
    );

    tmrwd_wdog #(.WDT_W(WDT_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wdt_clear),
        .inc     (wdt_inc),
        .timeout (wdt_timeout)
    );

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= cfg_new;
    end

    // Timer count: a write wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmr_q <= '0;
        else if (wr_cnt)  tmr_q <= reg_wdata;
        else if (tmr_inc) tmr_q <= tmr_q + 1'b1;
    end

    // Overflow flag: a wrap wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag_q <= 1'b0;
        else if (tmr_inc && tmr_q == TMR_MAX) flag_q <= 1'b1;
        else if (wr_flag)                     flag_q <= reg_wdata[0];
    end

    assign ovf_flag = flag_q;

    // Read-data mux.
    always_comb begin
        case (reg_addr)
            ADDR_COUNT: reg_rdata = tmr_q;
            ADDR_CFG:   reg_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
            ADDR_FLAG:  reg_rdata = {{(DATA_W-1){1'b0}}, flag_q};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmrwd_chk.sv
// Module: assertion checker for tmrwd_top, attached by bind. Assumes the
// active-low synchronous reset is applied at start.
module tmrwd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       wdt_clear,
    input logic       wdt_timeout,
    input logic       ovf_flag,
    input logic [7:0] tmr_q,
    input logic       psc_to_wdt,
    input logic       src_ext
);
    logic armed;

    // Becomes high once a clock edge has passed with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R6: a count write loads the written value.
    a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd0) |=> (tmr_q == $past(reg_wdata)));

    // R8: no timeout in the cycle after a clear.
    a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> !wdt_timeout);

    // R7: timeout lasts a single cycle.
    a_r7_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

    // R5: the flag rises only on a wrap or on a write that sets it.
    a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(ovf_flag) |-> (($past(tmr_q) == 8'hFF && tmr_q == 8'h00)
                             || $past(reg_wr_en && reg_addr == 2'd2 && reg_wdata[0])));

    // R3: internal source without the prescaler steps every cycle.
    a_r3_every_cycle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(psc_to_wdt && !src_ext && !(reg_wr_en && reg_addr == 2'd0))
        |-> (tmr_q == 8'($past(tmr_q) + 8'd1)));
endmodule

bind tmrwd_top tmrwd_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .wdt_clear   (wdt_clear),
    .wdt_timeout (wdt_timeout),
    .ovf_flag    (ovf_flag),
    .tmr_q       (tmr_q),
    .psc_to_wdt  (cfg_q.psc_to_wdt),
    .src_ext     (cfg_q.src_ext)
);

// File: tb/tmrwd_top_tb.sv
// Bench: a behavioural reference model stepped at every rising edge and
// compared one time unit later, plus targeted checks per requirement.
module tmrwd_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_clk_in = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_clear = 1'b0;
    logic       ovf_flag, wdt_timeout;

    int n_checks = 0;
    int n_fail = 0;
    int tick_mode = 0;
    int to_seen = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    tmrwd_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk_in(ext_clk_in),
        .wdt_tick(wdt_tick), .wdt_clear(wdt_clear), .ovf_flag(ovf_flag),
        .wdt_timeout(wdt_timeout)
    );

    task automatic check(string t, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
        end
    endtask

    // Reference model state
    int m_tmr, m_rate, m_asg, m_fall, m_src, m_flag, m_p, m_w, m_to;
    bit pinq[$];
    bit live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = 0; m_rate = 0; m_asg = 0; m_fall = 0; m_src = 0;
            m_flag = 0; m_p = 0; m_w = 0; m_to = 0;
            pinq = '{0, 0, 0};
            live = 1;
        end else if (live) begin
            bit edg, src_evt, own_evt, fire, wc, wg, wf, tinc, winc, clr;
            int mask, wd;
            wd  = reg_wdata;
            edg = m_fall ? (!pinq[1] && pinq[2]) : (pinq[1] && !pinq[2]);
            src_evt = m_src ? edg : 1'b1;
            own_evt = m_asg ? wdt_tick : src_evt;
            mask = m_asg ? ((1 << m_rate) - 1) : ((2 << m_rate) - 1);
            fire = own_evt && ((m_p & mask) == mask);
            wc = reg_wr_en && reg_addr == 2'd0;
            wg = reg_wr_en && reg_addr == 2'd1;
            wf = reg_wr_en && reg_addr == 2'd2;
            tinc = !wc && (m_asg ? src_evt : fire);
            winc = m_asg ? fire : wdt_tick;
            clr = (wc && !m_asg) || (wdt_clear && m_asg) || (wg && (((wd >> 3) & 1) != m_asg));
            if (tinc && m_tmr == 255) m_flag = 1; else if (wf) m_flag = wd & 1;
            if (wc) m_tmr = wd; else if (tinc) m_tmr = (m_tmr + 1) % 256;
            if (clr) m_p = 0; else if (own_evt) m_p = (m_p + 1) % 256;
            if (wdt_clear) begin m_w = 0; m_to = 0; end
            else if (winc) begin
                m_to = (m_w == 255);
                m_w = (m_w + 1) % 256;
            end else m_to = 0;
            if (wg) begin
                m_rate = wd & 7; m_asg = (wd >> 3) & 1;
                m_fall = (wd >> 4) & 1; m_src = (wd >> 5) & 1;
            end
            pinq.push_front(ext_clk_in);
            void'(pinq.pop_back());
        end
        #1;
        if (live) begin
            int exp_rd;
            case (reg_addr)
                2'd0: exp_rd = m_tmr;
                2'd1: exp_rd = m_rate | (m_asg << 3) | (m_fall << 4) | (m_src << 5);
                2'd2: exp_rd = m_flag;
                default: exp_rd = 0;
            endcase
            check({tag, " read data"}, reg_rdata, exp_rd);
            check({tag, " overflow flag"}, ovf_flag, m_flag);
            check({tag, " timeout"}, wdt_timeout, m_to);
            if (wdt_timeout) to_seen++;
        end
    end

    // Watchdog tick pattern
    always @(negedge clk) begin
        case (tick_mode)
            1: wdt_tick <= 1'b1;
            2: wdt_tick <= ($urandom % 3) != 0;
            default: wdt_tick <= 1'b0;
        endcase
    end

    // Watchdog for a hung run
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; cyc(3);
            ext_clk_in = 1'b0; cyc(3);
        end
    endtask

    initial begin
        int v0, v1;
        cyc(4);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, v0); check("R1 count", v0, 0);
        rd(2'd1, v0); check("R1 config", v0, 0);
        rd(2'd2, v0); check("R1 flag", v0, 0);
        check("R1 timeout", wdt_timeout, 0);

        // R10: register map readback
        tag = "R10";
        wr(2'd1, 8'hC2);
        rd(2'd1, v0); check("R10 config bits 7:6 read 0", v0, 8'h02);
        rd(2'd3, v0); check("R10 address 3 reads 0", v0, 0);

        // R2: prescaled internal count, rate 2 = 1:8
        tag = "R2";
        wr(2'd0, 8'h00);
        rd(2'd0, v0);
        cyc(32);
        rd(2'd0, v1); check("R2 rate 2 steps in 32 cycles", v1 - v0, 4);
        wr(2'd1, 8'h00);
        cyc(40);

        // R6: write loads and clears the prescaler
        tag = "R6";
        wr(2'd1, 8'h07);
        wr(2'd0, 8'h40);
        rd(2'd0, v0); check("R6 loaded value", v0, 8'h40);
        wr(2'd1, 8'h00);
        for (int i = 0; i < 6; i++) begin wr(2'd0, 8'h10 + i); cyc(i); end

        // R5: overflow sets the flag, then software clears it
        tag = "R5";
        wr(2'd0, 8'hFD);
        cyc(10);
        check("R5 flag after wrap", ovf_flag, 1);
        wr(2'd2, 8'h00);
        check("R5 flag cleared by write", ovf_flag, 0);

        // R7: watchdog timeout with ticks every cycle
        tag = "R7";
        tick_mode = 1;
        @(negedge clk); wdt_clear = 1'b1; @(negedge clk); wdt_clear = 1'b0;
        v0 = to_seen;
        cyc(300);
        check("R7 one timeout in 300 ticks", to_seen - v0, 1);

        // R8: periodic clears hold off the timeout
        tag = "R8";
        v0 = to_seen;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); wdt_clear = 1'b1; @(negedge clk); wdt_clear = 1'b0;
            cyc(100);
        end
        check("R8 no timeout with clears", to_seen - v0, 0);

        // R3: prescaler on watchdog, timer counts every cycle
        tag = "R3";
        tick_mode = 2;
        wr(2'd1, 8'h09);
        rd(2'd0, v0);
        cyc(10);
        rd(2'd0, v1); check("R3 timer steps each cycle", (v1 - v0) & 255, 10);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); wdt_clear = 1'b1; @(negedge clk); wdt_clear = 1'b0;
            cyc(50);
        end

        // R9: ownership swaps clear the prescaler
        tag = "R9";
        for (int i = 0; i < 6; i++) begin
            wr(2'd1, (i % 2) ? 8'h08 : 8'h01);
            cyc(3 + i);
        end

        // R4: external pin, rising then falling edges
        tag = "R4";
        wr(2'd1, 8'h28);
        cyc(5);
        rd(2'd0, v0);
        pulses(5);
        cyc(4);
        rd(2'd0, v1); check("R4 rising edges counted", (v1 - v0) & 255, 5);
        wr(2'd1, 8'h38);
        cyc(5);
        rd(2'd0, v0);
        pulses(5);
        cyc(5);
        rd(2'd0, v1); check("R4 falling edges counted", (v1 - v0) & 255, 5);
        wr(2'd1, 8'h20);
        pulses(20);

        // R7: watchdog owning the prescaler at rate 1
        tag = "R7";
        tick_mode = 1;
        wr(2'd1, 8'h09);
        @(negedge clk); wdt_clear = 1'b1; @(negedge clk); wdt_clear = 1'b0;
        v0 = to_seen;
        cyc(560);
        check("R7 one timeout at 1:2 watchdog ratio", to_seen - v0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule